// File: doc/BRIEF.md
# Bridge Interrupt Control and Status Register

This block is a 16-bit control register that a bus bridge uses to combine its error and event sources into interrupt lines. Software writes it through a simple write port with byte enables and can always read its current value on a read-data bus. The block does not store any status. Abort flags, the parity-error flag, doorbell pending bits, the local interrupt request and the self-test completion flag all arrive as levels. Logic elsewhere holds and clears them.

Three registered interrupt lines come out of the block. The local error line reports aborts and parity errors, with a separate enable for each cause. The host interrupt line merges doorbell, abort and local-request causes. Each of these has its own enable, and a global host enable gates all three. The local interrupt line reports self-test completion under its own enable. The block can also send a one-cycle system-error request to the host bus when software writes a fire bit.

Top module: `brg_irq_ctrl`

## Requirements
- R1: After reset `rd_data` reads 0x0100 (global host enable in bit 8 set, every other bit clear), and `lerr_irq`, `host_irq`, `local_irq` and `serr_pulse` are 0.
- R2: When bit 0 is 1 and `tgt_abort` or `mst_abort` is 1, `lerr_irq` is 1 one cycle later. When bit 0 is 0, aborts do not raise `lerr_irq`.
- R3: When bit 1 is 1 and `parity_err` is 1, `lerr_irq` is 1 one cycle later. When bit 1 is 0, parity errors do not raise `lerr_irq`.
- R4: A write with `wr_be[0]`=1 and `wr_data[2]`=1, made while bit 2 reads 0, sets bit 2 and raises `serr_pulse` for exactly the next cycle. Bit 2 then reads 0 again. A write of 1 made while bit 2 reads 1 fires nothing, so writes on every cycle give a pulse every other cycle.
- R5: Bits 7:3 and 15:13 always read 0. Writes to those bits have no effect.
- R6: `host_irq` equals the registered value of bit8&((bit9 & any `doorbell_pend` bit) | (bit10 & (`tgt_abort`|`mst_abort`)) | (bit11 & `local_irq_in`)). With bit 8 clear it stays 0.
- R7: The host and local interrupt lines are level-type. They stay asserted while their cause is present, even across register writes that keep the enables set. They fall one cycle after the cause is removed.
- R8: `wr_be[0]` gates bits 7:0 and `wr_be[1]` gates bits 15:8. A byte whose enable is 0 keeps its value.
- R9: Bit 12 enables self-test completion. `local_irq` is the registered value of bit12 & `selftest_done`.
- R10: Every interrupt output follows a change of its source inputs after one clock edge. It follows a register write after two clock edges: one to update the register, one to update the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_be | input | 2 | Byte enables of the write |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Current register value |
| tgt_abort | input | 1 | Target-abort status level |
| mst_abort | input | 1 | Master-abort status level |
| parity_err | input | 1 | Parity-error status level |
| doorbell_pend | input | DB_W | Doorbell pending bits |
| local_irq_in | input | 1 | Local-side interrupt request to the host |
| selftest_done | input | 1 | Self-test completion flag |
| lerr_irq | output | 1 | Local error interrupt |
| host_irq | output | 1 | Host-bus interrupt |
| local_irq | output | 1 | Local interrupt (self-test completion) |
| serr_pulse | output | 1 | One-cycle host system-error request |

## Verification
A wrong enable bit in the register shows up on `rd_data` right after the write edge. It also shows up on the matching interrupt line one edge later, as long as a cause is driven. A fire bit that fails to self-clear appears as a `serr_pulse` lasting two or more cycles, or as bit 2 reading 1 after the pulse. Neither case can go unseen for more than one cycle. The bench drives random causes and enables and compares each output against a bench model on every step. Because every output depends on just one register stage past the register, any fault is caught within two cycles of the stimulus.

// File: rtl/brg_irq_pkg.sv
package brg_irq_pkg;

    localparam int REG_W  = 16;
    localparam int BE_W   = REG_W / 8;

    // bit positions decoded by software
    localparam int B_LERR_ABT = 0;
    localparam int B_LERR_PAR = 1;
    localparam int B_SERR     = 2;
    localparam int B_HOST_EN  = 8;
    localparam int B_DB_EN    = 9;
    localparam int B_ABT_EN   = 10;
    localparam int B_LIN_EN   = 11;
    localparam int B_BIST_EN  = 12;

    typedef struct packed {
        logic lerr_abt_en;
        logic lerr_par_en;
        logic serr_req;
        logic host_en;
        logic db_en;
        logic abt_en;
        logic lin_en;
        logic bist_en;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{
        lerr_abt_en: 1'b0,
        lerr_par_en: 1'b0,
        serr_req:    1'b0,
        host_en:     1'b1,
        db_en:       1'b0,
        abt_en:      1'b0,
        lin_en:      1'b0,
        bist_en:     1'b0
    };

endpackage

// File: rtl/brg_irq_regs.sv
module brg_irq_regs
    import brg_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [BE_W-1:0]  wr_be,
    input  logic [REG_W-1:0] wr_data,
    output ctrl_t            ctrl,
    output logic [REG_W-1:0] rd_data
);

    typedef struct packed {
        ctrl_t ctrl;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // fire bit lives for one cycle only
        if (st_q.ctrl.serr_req) begin
            st_d.ctrl.serr_req = 1'b0;
        end
        if (wr_en) begin
            if (wr_be[0]) begin
                st_d.ctrl.lerr_abt_en = wr_data[B_LERR_ABT];
                st_d.ctrl.lerr_par_en = wr_data[B_LERR_PAR];
                if (wr_data[B_SERR] && !st_q.ctrl.serr_req) begin
                    st_d.ctrl.serr_req = 1'b1;
                end
            end
            if (wr_be[1]) begin
                st_d.ctrl.host_en = wr_data[B_HOST_EN];
                st_d.ctrl.db_en   = wr_data[B_DB_EN];
                st_d.ctrl.abt_en  = wr_data[B_ABT_EN];
                st_d.ctrl.lin_en  = wr_data[B_LIN_EN];
                st_d.ctrl.bist_en = wr_data[B_BIST_EN];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ctrl: CTRL_RST};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_data             = '0;
        rd_data[B_LERR_ABT] = st_q.ctrl.lerr_abt_en;
        rd_data[B_LERR_PAR] = st_q.ctrl.lerr_par_en;
        rd_data[B_SERR]     = st_q.ctrl.serr_req;
        rd_data[B_HOST_EN]  = st_q.ctrl.host_en;
        rd_data[B_DB_EN]    = st_q.ctrl.db_en;
        rd_data[B_ABT_EN]   = st_q.ctrl.abt_en;
        rd_data[B_LIN_EN]   = st_q.ctrl.lin_en;
        rd_data[B_BIST_EN]  = st_q.ctrl.bist_en;
    end

    assign ctrl = st_q.ctrl;

endmodule

// File: rtl/brg_irq_merge.sv
module brg_irq_merge #(
    parameter int NSRC    = 2,
    parameter bit REG_OUT = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            gate,
    input  logic [NSRC-1:0] en,
    input  logic [NSRC-1:0] cause,
    output logic            irq
);

    logic [NSRC-1:0] hit;
    logic            irq_d;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        assign hit[i] = en[i] & cause[i];
    end

    always_comb begin
        irq_d = gate & (|hit);
    end

    if (REG_OUT) begin : g_reg
        logic irq_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                irq_q <= 1'b0;
            end else begin
                irq_q <= irq_d;
            end
        end
        assign irq = irq_q;
    end else begin : g_comb
        logic unused_clk;
        assign unused_clk = clk ^ rst_n;
        assign irq = irq_d;
    end

endmodule

// File: rtl/brg_irq_ctrl.sv
module brg_irq_ctrl
    import brg_irq_pkg::*;
#(
    parameter int DB_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_be,
    input  logic [15:0]      wr_data,
    output logic [15:0]      rd_data,
    input  logic             tgt_abort,
    input  logic             mst_abort,
    input  logic             parity_err,
    input  logic [DB_W-1:0]  doorbell_pend,
    input  logic             local_irq_in,
    input  logic             selftest_done,
    output logic             lerr_irq,
    output logic             host_irq,
    output logic             local_irq,
    output logic             serr_pulse
);

    ctrl_t ctrl;
    logic  any_abort;
    logic  any_db;

    brg_irq_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_be   (wr_be),
        .wr_data (wr_data),
        .ctrl    (ctrl),
        .rd_data (rd_data)
    );

    assign any_abort = tgt_abort | mst_abort;
    assign any_db    = |doorbell_pend;

    brg_irq_merge #(.NSRC(2), .REG_OUT(1'b1)) u_lerr (
        .clk   (clk),
        .rst_n (rst_n),
        .gate  (1'b1),
        .en    ({ctrl.lerr_par_en, ctrl.lerr_abt_en}),
        .cause ({parity_err, any_abort}),
        .irq   (lerr_irq)
    );

    brg_irq_merge #(.NSRC(3), .REG_OUT(1'b1)) u_host (
        .clk   (clk),
        .rst_n (rst_n),
        .gate  (ctrl.host_en),
        .en    ({ctrl.lin_en, ctrl.abt_en, ctrl.db_en}),
        .cause ({local_irq_in, any_abort, any_db}),
        .irq   (host_irq)
    );

    brg_irq_merge #(.NSRC(1), .REG_OUT(1'b1)) u_local (
        .clk   (clk),
        .rst_n (rst_n),
        .gate  (1'b1),
        .en    (ctrl.bist_en),
        .cause (selftest_done),
        .irq   (local_irq)
    );

    assign serr_pulse = ctrl.serr_req;

endmodule

// File: rtl/brg_irq_ctrl_chk.sv
module brg_irq_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] rd_data,
    input logic        tgt_abort,
    input logic        mst_abort,
    input logic        parity_err,
    input logic        selftest_done,
    input logic        lerr_irq,
    input logic        host_irq,
    input logic        local_irq,
    input logic        serr_pulse
);

    p_serr_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        serr_pulse |=> !serr_pulse);

    p_serr_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        serr_pulse |=> !rd_data[2]);

    p_rsvd_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[7:3] == 5'd0) && (rd_data[15:13] == 3'd0));

    p_host_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[8] |=> !host_irq);

    p_lerr_abort_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[0] && (tgt_abort || mst_abort)) |=> lerr_irq);

    p_lerr_parity_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[1] && parity_err) |=> lerr_irq);

    p_lerr_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[1:0] == 2'b00) |=> !lerr_irq);

    p_local_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[12] && selftest_done) |=> local_irq);

    p_local_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !selftest_done |=> !local_irq);

endmodule

bind brg_irq_ctrl brg_irq_ctrl_chk u_chk (.*);

// File: tb/brg_irq_ctrl_bench.sv
module brg_irq_ctrl_bench;

    localparam int DB_W = 8;
    localparam logic [15:0] IMPL_MASK = 16'h1F03;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en = 1'b0;
    logic [1:0]      wr_be = 2'b00;
    logic [15:0]     wr_data = '0;
    logic [15:0]     rd_data;
    logic            tgt_abort = 1'b0;
    logic            mst_abort = 1'b0;
    logic            parity_err = 1'b0;
    logic [DB_W-1:0] doorbell_pend = '0;
    logic            local_irq_in = 1'b0;
    logic            selftest_done = 1'b0;
    logic            lerr_irq, host_irq, local_irq, serr_pulse;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] m_reg;

    always #10 clk = ~clk;

    brg_irq_ctrl #(.DB_W(DB_W)) u_brg_irq_ctrl (.*);

    function automatic logic [15:0] f_write(logic [15:0] old, logic [1:0] be, logic [15:0] d);
        logic [15:0] r = old;
        if (be[0]) r[1:0] = d[1:0];
        if (be[1]) r[12:8] = d[12:8];
        return r;
    endfunction

    function automatic logic f_host(logic [15:0] c, logic [DB_W-1:0] db, logic ta, logic ma, logic li);
        return c[8] & ((c[9] & (|db)) | (c[10] & (ta | ma)) | (c[11] & li));
    endfunction

    function automatic logic f_lerr(logic [15:0] c, logic ta, logic ma, logic pe);
        return (c[0] & (ta | ma)) | (c[1] & pe);
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_outs(string req);
        check({req, " lerr"}, {15'd0, lerr_irq},
              {15'd0, f_lerr(m_reg, tgt_abort, mst_abort, parity_err)});
        check({req, " host"}, {15'd0, host_irq},
              {15'd0, f_host(m_reg, doorbell_pend, tgt_abort, mst_abort, local_irq_in)});
        check({req, " local"}, {15'd0, local_irq}, {15'd0, m_reg[12] & selftest_done});
    endtask

    // one step: optional write plus source levels, held two edges
    task automatic step(logic we, logic [1:0] be, logic [15:0] d,
                        logic ta, logic ma, logic pe, logic [DB_W-1:0] db,
                        logic li, logic st, string req);
        logic fire;
        @(negedge clk);
        wr_en = we; wr_be = be; wr_data = d;
        tgt_abort = ta; mst_abort = ma; parity_err = pe;
        doorbell_pend = db; local_irq_in = li; selftest_done = st;
        fire = we & be[0] & d[2];
        if (we) m_reg = f_write(m_reg, be, d);
        @(negedge clk);
        wr_en = 1'b0;
        check({req, " R4 pulse"}, {15'd0, serr_pulse}, {15'd0, fire});
        check({req, " R8 rd"}, rd_data, m_reg | {13'd0, fire, 2'd0});
        @(negedge clk);
        check({req, " R4 R5 rd"}, rd_data, m_reg);
        check_outs({req, " R10"});
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        m_reg = 16'h0100;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 rd", rd_data, 16'h0100);
        check("R1 outs", {12'd0, lerr_irq, host_irq, local_irq, serr_pulse}, 16'd0);

        // R5 reserved bits ignore writes
        step(1'b1, 2'b11, 16'hE0F8, 0, 0, 0, '0, 0, 0, "R5 rsvd");
        // R2 abort enable
        step(1'b1, 2'b11, 16'h0101, 1, 0, 0, '0, 0, 0, "R2 abort");
        step(1'b0, 2'b00, 16'h0000, 0, 1, 0, '0, 0, 0, "R2 mst");
        // R3 parity
        step(1'b1, 2'b01, 16'h0002, 0, 0, 1, '0, 0, 0, "R3 parity");
        // R6 gating: per-source enables without global
        step(1'b1, 2'b10, 16'h0E00, 1, 0, 0, 8'h10, 1, 0, "R6 gated off");
        step(1'b1, 2'b10, 16'h0F00, 1, 0, 0, 8'h10, 1, 0, "R6 on");
        // R7 level: write keeping enables does not clear
        step(1'b1, 2'b11, 16'h0F00, 0, 0, 0, 8'h01, 0, 0, "R7 hold");
        step(1'b0, 2'b00, 16'h0000, 0, 0, 0, 8'h00, 0, 0, "R7 cleared");
        // R9 self-test
        step(1'b1, 2'b10, 16'h1000, 0, 0, 0, '0, 0, 1, "R9 on");
        step(1'b0, 2'b00, 16'h0000, 0, 0, 0, '0, 0, 0, "R9 off");
        // R8 byte enable masking
        step(1'b1, 2'b01, 16'hFFFB, 0, 0, 0, '0, 0, 0, "R8 lo only");

        // R4 back-to-back writes: pulse every other cycle
        @(negedge clk);
        wr_en = 1'b1; wr_be = 2'b01; wr_data = 16'h0004 | {14'd0, m_reg[1:0]};
        @(negedge clk);
        check("R4 b2b first", {15'd0, serr_pulse}, 16'd1);
        @(negedge clk);
        check("R4 b2b no refire", {15'd0, serr_pulse}, 16'd0);
        @(negedge clk);
        check("R4 b2b third", {15'd0, serr_pulse}, 16'd1);
        wr_en = 1'b0;
        @(negedge clk);
        check("R4 b2b end", {15'd0, serr_pulse}, 16'd0);
        check("R4 readback", {15'd0, rd_data[2]}, 16'd0);

        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r = $urandom;
            logic [31:0] s = $urandom;
            step(r[0], r[2:1], r[31:16], s[0] & s[1], s[2] & s[3], s[4] & s[5],
                 (s[6] & s[7]) ? s[15:8] : '0, s[16], s[17], "R6 R9 rand");
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule